// File: doc/BRIEF.md
# Interrupt Presentation Controller

This block sits beside one processor core and decides which of two interrupt sources, if any, is presented to it. One source is a level-sensitive device line. The other is an inter-processor interrupt that software raises by storing a priority byte. The block drives one external-interrupt request to the core. Software reaches four word-aligned registers over a simple request/response bus.

A smaller priority number is more favoured. A source is presented only when its priority is numerically below the current processor priority held in the block. Software reads the pending word to acknowledge the presented source. That read returns the source identifier and the old current priority, and it raises the current priority so that the request drops. Writing the same word back ends the interrupt and restores the old priority. A second register offset returns the same word without any side effect, so software can poll it.

Top module: `ipc_top`

## Requirements
- R1: After reset the current priority is 0x00, the IPI priority register is 0xFF, `ext_irq_o` is low and `rsp_valid_o` is low.
- R2: A source is presented, and `ext_irq_o` is high, only while that source's priority is numerically less than the current priority. The device source has the fixed priority 0x80. The IPI source uses the value of its priority register.
- R3: When both sources qualify, the one with the smaller priority number is presented. On equal priority the IPI wins. In bits 23:0 of the pending word, the IPI identifier is 2, the device identifier is 16, and 0 means nothing is presented.
- R4: A write to offset 0x4 sets the current priority. A byte write (`req_word_i`=0) takes it from `req_wdata_i[7:0]`. A word write (`req_word_i`=1) ends the interrupt and takes it from `req_wdata_i[31:24]`.
- R5: A write to offset 0xC stores `req_wdata_i[7:0]` as the IPI priority. Any value other than 0xFF makes the IPI pending, and 0xFF clears it. A read of 0xC returns the register in bits 7:0, with zeros above.
- R6: A read of offset 0x4 returns {current priority, 24-bit presented identifier} one cycle later, with `rsp_valid_o` high. If a source was presented, the current priority becomes that source's priority and `ext_irq_o` drops.
- R7: A read of offset 0x0 returns the same word as R6 and changes nothing.
- R8: A source that is pending while masked stays pending. It is presented as soon as the current priority is raised above its priority.
- R9: An acknowledge does not clear the device source. After the end of interrupt it is presented again for as long as `dev_irq_i` stays high, and it stops only when the line falls.
- R10: Offset 0x8 reads as zero, and a write to it changes no state.
- R11: `dev_irq_i` and register writes are sampled on a rising clock edge, and `ext_irq_o` reflects them right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_irq_i | input | 1 | Level-sensitive device interrupt |
| req_valid_i | input | 1 | Bus request strobe, one cycle per access |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_word_i | input | 1 | 1 = 32-bit access, 0 = byte access |
| req_addr_i | input | ADDR_W | Byte offset; bits 3:2 select the register |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read request |
| rsp_data_o | output | 32 | Read data |
| ext_irq_o | output | 1 | External-interrupt request to the core |

## Verification
A wrong current-priority value shows up in two places. The request line rises or falls on the wrong side of a source's priority in the cycle after the write that set it. The next poll of offset 0x0 then returns the wrong upper byte. A wrong pending or arbitration state shows up as a wrong identifier in the low 24 bits, one cycle after a poll or acknowledge. A lost device level shows up when, after the end of interrupt, the request line fails to return on the following cycle.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

    localparam int PRIO_W = 8;
    localparam int ID_W   = 24;
    localparam int WORD_W = PRIO_W + ID_W;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [ID_W-1:0]   src_id_t;

    localparam prio_t PRIO_NONE = '1;   // least favoured / "off"
    localparam prio_t PRIO_MASK = '0;   // masks everything

    typedef enum logic [1:0] {
        SEL_POLL = 2'd0,
        SEL_ACK  = 2'd1,
        SEL_RSVD = 2'd2,
        SEL_IPI  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic    valid;
        prio_t   prio;
        src_id_t id;
    } cand_t;

    // a is preferred on equal priority
    function automatic cand_t pick_favoured(cand_t a, cand_t b);
        if (a.valid && (!b.valid || a.prio <= b.prio))
            return a;
        return b;
    endfunction

    function automatic logic [WORD_W-1:0] pack_pending(prio_t cur, src_id_t id);
        return {cur, id};
    endfunction

endpackage

// File: rtl/ipc_sources.sv
module ipc_sources
    import ipc_pkg::*;
#(
    parameter prio_t   DEV_PRIO = 8'h80,
    parameter src_id_t IPI_ID   = 24'd2,
    parameter src_id_t DEV_ID   = 24'd16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               dev_irq_i,
    input  logic               ipi_we_i,
    input  prio_t              ipi_wdata_i,
    output prio_t              ipi_prio_o,
    output cand_t [1:0]        cands_o
);
    prio_t ipi_prio_q;
    logic  dev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ipi_prio_q <= PRIO_NONE;
            dev_q      <= 1'b0;
        end else begin
            dev_q <= dev_irq_i;
            if (ipi_we_i)
                ipi_prio_q <= ipi_wdata_i;
        end
    end

    // index 0 is the IPI so that it wins ties
    always_comb begin
        cands_o[0].valid = (ipi_prio_q != PRIO_NONE);
        cands_o[0].prio  = ipi_prio_q;
        cands_o[0].id    = IPI_ID;
        cands_o[1].valid = dev_q;
        cands_o[1].prio  = DEV_PRIO;
        cands_o[1].id    = DEV_ID;
    end

    assign ipi_prio_o = ipi_prio_q;

endmodule

// File: rtl/ipc_arbiter.sv
module ipc_arbiter
    import ipc_pkg::*;
#(
    parameter int NUM_SRC = 2
) (
    input  cand_t [NUM_SRC-1:0] cands_i,
    input  prio_t               cur_prio_i,
    output cand_t               best_o,
    output logic                present_o
);
    cand_t [NUM_SRC:0] chain;

    assign chain[NUM_SRC] = '0;

    for (genvar g = NUM_SRC - 1; g >= 0; g--) begin : g_chain
        assign chain[g] = pick_favoured(cands_i[g], chain[g+1]);
    end

    assign best_o    = chain[0];
    assign present_o = chain[0].valid && (chain[0].prio < cur_prio_i);

endmodule

// File: rtl/ipc_regs.sv
module ipc_regs
    import ipc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic              req_word_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [WORD_W-1:0] req_wdata_i,
    input  cand_t             best_i,
    input  logic              present_i,
    input  prio_t             ipi_prio_i,
    output prio_t             cur_prio_o,
    output logic              ipi_we_o,
    output prio_t             ipi_wdata_o,
    output logic              rsp_valid_o,
    output logic [WORD_W-1:0] rsp_data_o
);
    reg_sel_e          sel;
    logic              rd, wr;
    prio_t             cur_q;
    logic [WORD_W-1:0] pend_word;

    assign sel       = reg_sel_e'(req_addr_i[3:2]);
    assign rd        = req_valid_i && !req_write_i;
    assign wr        = req_valid_i &&  req_write_i;
    assign pend_word = pack_pending(cur_q, present_i ? best_i.id : '0);

    assign ipi_we_o    = wr && (sel == SEL_IPI);
    assign ipi_wdata_o = req_wdata_i[PRIO_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q       <= PRIO_MASK;
            rsp_valid_o <= 1'b0;
            rsp_data_o  <= '0;
        end else begin
            rsp_valid_o <= rd;
            if (rd) begin
                unique case (sel)
                    SEL_POLL, SEL_ACK: rsp_data_o <= pend_word;
                    SEL_RSVD:          rsp_data_o <= '0;
                    SEL_IPI:           rsp_data_o <= {{(WORD_W-PRIO_W){1'b0}}, ipi_prio_i};
                    default:           rsp_data_o <= '0;
                endcase
                if (sel == SEL_ACK && present_i)
                    cur_q <= best_i.prio;
            end
            if (wr && sel == SEL_ACK)
                cur_q <= req_word_i ? req_wdata_i[WORD_W-1 -: PRIO_W]
                                    : req_wdata_i[PRIO_W-1:0];
        end
    end

    assign cur_prio_o = cur_q;

endmodule

// File: rtl/ipc_top.sv
module ipc_top
    import ipc_pkg::*;
#(
    parameter int      ADDR_W   = 4,
    parameter prio_t   DEV_PRIO = 8'h80,
    parameter src_id_t IPI_ID   = 24'd2,
    parameter src_id_t DEV_ID   = 24'd16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dev_irq_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic              req_word_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [31:0]       req_wdata_i,
    output logic              rsp_valid_o,
    output logic [31:0]       rsp_data_o,
    output logic              ext_irq_o
);
    localparam int NUM_SRC = 2;

    cand_t [NUM_SRC-1:0] cands;
    cand_t               best;
    logic                present;
    prio_t               cur_prio;
    prio_t               ipi_prio;
    logic                ipi_we;
    prio_t               ipi_wdata;
    logic                dev_pending;

    ipc_sources #(
        .DEV_PRIO (DEV_PRIO),
        .IPI_ID   (IPI_ID),
        .DEV_ID   (DEV_ID)
    ) u_src (
        .clk         (clk),
        .rst         (rst),
        .dev_irq_i   (dev_irq_i),
        .ipi_we_i    (ipi_we),
        .ipi_wdata_i (ipi_wdata),
        .ipi_prio_o  (ipi_prio),
        .cands_o     (cands)
    );

    ipc_arbiter #(
        .NUM_SRC (NUM_SRC)
    ) u_arb (
        .cands_i    (cands),
        .cur_prio_i (cur_prio),
        .best_o     (best),
        .present_o  (present)
    );

    ipc_regs #(
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .req_valid_i (req_valid_i),
        .req_write_i (req_write_i),
        .req_word_i  (req_word_i),
        .req_addr_i  (req_addr_i),
        .req_wdata_i (req_wdata_i),
        .best_i      (best),
        .present_i   (present),
        .ipi_prio_i  (ipi_prio),
        .cur_prio_o  (cur_prio),
        .ipi_we_o    (ipi_we),
        .ipi_wdata_o (ipi_wdata),
        .rsp_valid_o (rsp_valid_o),
        .rsp_data_o  (rsp_data_o)
    );

    assign dev_pending = cands[1].valid;
    assign ext_irq_o   = present;

endmodule

// File: rtl/ipc_checker.sv
module ipc_checker
    import ipc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid_i,
    input logic              req_write_i,
    input logic [ADDR_W-1:0] req_addr_i,
    input logic              rsp_valid_o,
    input logic [31:0]       rsp_data_o,
    input logic              ext_irq_o,
    input prio_t             cur_prio,
    input prio_t             ipi_prio,
    input logic              dev_pending
);
    logic rd_ack, rd_poll, rd_pend, wr_rsvd;

    assign rd_ack  = req_valid_i && !req_write_i && req_addr_i[3:2] == 2'd1;
    assign rd_poll = req_valid_i && !req_write_i && req_addr_i[3:2] == 2'd0;
    assign rd_pend = rd_ack || rd_poll;
    assign wr_rsvd = req_valid_i &&  req_write_i && req_addr_i[3:2] == 2'd2;

    // R2: request only with some pending source
    a_r2_request_has_source: assert property (@(posedge clk) disable iff (rst)
        ext_irq_o |-> (dev_pending || ipi_prio != PRIO_NONE));

    // R2: fully masked means no request
    a_r2_mask_all: assert property (@(posedge clk) disable iff (rst)
        (cur_prio == PRIO_MASK) |-> !ext_irq_o);

    // R6: acknowledge of a presented source drops the request
    a_r6_ack_drops: assert property (@(posedge clk) disable iff (rst)
        (rd_ack && ext_irq_o) |=> !ext_irq_o);

    // R6: every read answers next cycle, writes do not
    a_r6_rsp_follows_read: assert property (@(posedge clk) disable iff (rst)
        req_valid_i |=> (rsp_valid_o == !$past(req_write_i)));

    // R3: non-zero identifier exactly when something was presented
    a_r3_id_matches_request: assert property (@(posedge clk) disable iff (rst)
        rd_pend |=> ((rsp_data_o[23:0] != 24'd0) == $past(ext_irq_o)));

    // R7: polling leaves the current priority alone
    a_r7_poll_no_effect: assert property (@(posedge clk) disable iff (rst)
        rd_poll |=> $stable(cur_prio));

    // R10: reserved writes touch nothing
    a_r10_rsvd_write: assert property (@(posedge clk) disable iff (rst)
        wr_rsvd |=> ($stable(cur_prio) && $stable(ipi_prio)));

endmodule

bind ipc_top ipc_checker #(.ADDR_W(ADDR_W)) u_ipc_checker (
    .clk         (clk),
    .rst         (rst),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_data_o  (rsp_data_o),
    .ext_irq_o   (ext_irq_o),
    .cur_prio    (cur_prio),
    .ipi_prio    (ipi_prio),
    .dev_pending (dev_pending)
);

// File: tb/tb_ipc_top.sv
module tb_ipc_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dev_irq = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_word = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        ext_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;   // 250 MHz

    ipc_top dut (
        .clk         (clk),
        .rst         (rst),
        .dev_irq_i   (dev_irq),
        .req_valid_i (req_valid),
        .req_write_i (req_write),
        .req_word_i  (req_word),
        .req_addr_i  (req_addr),
        .req_wdata_i (req_wdata),
        .rsp_valid_o (rsp_valid),
        .rsp_data_o  (rsp_data),
        .ext_irq_o   (ext_irq)
    );

    task automatic check_bit(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: ext_irq actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R6: unexpected response actual %h expected none", rsp_data);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rsp_data !== e) begin
                    fails++;
                    $display("FAIL %s: read data actual %h expected %h", t, rsp_data, e);
                end
            end
        end
    end

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d, input logic word);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_word = word;
        req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_word = 1'b1; req_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R11: watchdog actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check_bit(ext_irq, 1'b0, "R1");
        checks++;
        if (rsp_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: rsp_valid actual %0b expected 0", rsp_valid);
        end
        bus_read(4'h0, 32'h0000_0000, "R1");
        bus_read(4'hC, 32'h0000_00FF, "R1");

        // R8: sources pending while fully masked
        dev_irq = 1'b1;
        bus_write(4'hC, 32'h0000_0005, 1'b0);
        check_bit(ext_irq, 1'b0, "R8");
        bus_read(4'hC, 32'h0000_0005, "R5");

        // R2: 0x40 lets IPI (0x05) in, holds device (0x80)
        bus_write(4'h4, 32'h0000_0040, 1'b0);
        check_bit(ext_irq, 1'b1, "R2");
        bus_read(4'h0, 32'h4000_0002, "R7");
        bus_read(4'h0, 32'h4000_0002, "R7");
        check_bit(ext_irq, 1'b1, "R7");

        // R6: acknowledge
        bus_read(4'h4, 32'h4000_0002, "R6");
        check_bit(ext_irq, 1'b0, "R6");
        bus_read(4'h0, 32'h0500_0000, "R6");

        // R5 clear IPI, R4 EOI restores 0x40; device still held off (R2)
        bus_write(4'hC, 32'h0000_00FF, 1'b0);
        bus_write(4'h4, 32'h4000_0002, 1'b1);
        check_bit(ext_irq, 1'b0, "R2");
        bus_read(4'h0, 32'h4000_0000, "R4");

        // R8: relax to 0xC0, device shows
        bus_write(4'h4, 32'h0000_00C0, 1'b0);
        check_bit(ext_irq, 1'b1, "R8");
        bus_read(4'h4, 32'hC000_0010, "R6");
        check_bit(ext_irq, 1'b0, "R6");
        bus_read(4'h0, 32'h8000_0000, "R6");

        // R9: EOI with line still high re-presents
        bus_write(4'h4, 32'hC000_0010, 1'b1);
        check_bit(ext_irq, 1'b1, "R9");
        bus_read(4'h0, 32'hC000_0010, "R9");
        dev_irq = 1'b0;
        @(negedge clk);
        check_bit(ext_irq, 1'b0, "R9");

        // R11: edge-sampled device line
        dev_irq = 1'b1;
        #1;
        check_bit(ext_irq, 1'b0, "R11");
        @(negedge clk);
        check_bit(ext_irq, 1'b1, "R11");

        // R3: arbitration with current priority 0xFF
        bus_write(4'h4, 32'h0000_00FF, 1'b0);
        bus_write(4'hC, 32'h0000_0090, 1'b0);
        bus_read(4'h0, 32'hFF00_0010, "R3");
        bus_write(4'hC, 32'h0000_0080, 1'b0);
        bus_read(4'h0, 32'hFF00_0002, "R3");
        bus_write(4'hC, 32'h0000_0005, 1'b0);
        bus_read(4'h0, 32'hFF00_0002, "R3");

        // R10: reserved slot
        bus_write(4'h8, 32'hFFFF_FFFF, 1'b1);
        bus_read(4'h8, 32'h0000_0000, "R10");
        bus_read(4'h0, 32'hFF00_0002, "R10");
        bus_read(4'hC, 32'h0000_0005, "R10");

        // R6: acknowledge with nothing presented
        dev_irq = 1'b0;
        bus_write(4'hC, 32'h0000_00FF, 1'b0);
        bus_write(4'h4, 32'h0000_0000, 1'b0);
        bus_read(4'h4, 32'h0000_0000, "R6");
        bus_read(4'h0, 32'h0000_0000, "R6");
        check_bit(ext_irq, 1'b0, "R6");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R6: pending responses actual %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        finish_run();
    end

endmodule